// File: doc/BRIEF.md
# Retriggerable Retentive Delay Timer

This block is a down-counting delay timer paced by a tick enable. It watches a run input for edges, loads a preset count when a start edge arrives, decrements that count once per ticked clock cycle and reports a single status bit plus the remaining count. One of two behaviours is chosen at elaboration through the `MODE` parameter.

In the retentive on-delay variant, a rising edge of the run input starts the count. The status bit goes high once the count has fully run out. It then stays high whatever the run input does, until the clear input is pulsed. A rising edge that arrives while the count is still going reloads the full preset.

In the off-delay variant, a falling edge of the run input starts the count. The status bit stays high as long as the run input was high in the previous cycle, or as long as the count is still going. Typical uses are holding a drive on for a fixed time after its request drops, and latching a fault once a condition has persisted long enough.

Top module: `rdt_timer`

## Requirements
- R1: In on-delay mode (`MODE` = `MODE_ON_RET`, encoding 0), a rising edge of `run_i` in a cycle without `clr_i`, while the timer has not expired, makes `remain_o` equal to `preset_i` after the next clock edge and starts the count. An edge is detected by comparing `run_i` with its value registered on the previous clock.
- R2: While the count is going, `remain_o` drops by exactly 1 after each clock edge at which `tick_i` is 1. It holds its value when `tick_i` is 0 and never goes below 0.
- R3: In on-delay mode, `status_o` becomes 1 after the clock edge at which `remain_o` steps from 1 to 0. With a preset of 0 it becomes 1 after the clock edge that samples the start edge.
- R4: In on-delay mode, a falling edge of `run_i` leaves `status_o` unchanged and does not stop the count.
- R5: In on-delay mode, a rising edge of `run_i` while the count is still going reloads `remain_o` with the full `preset_i`.
- R6: In on-delay mode, once the timer has expired, further rising edges of `run_i` have no effect: `status_o` stays 1 and `remain_o` stays 0 until `clr_i` is applied.
- R7: `clr_i` = 1 stops the count, sets `remain_o` to 0 and, in on-delay mode, sets `status_o` to 0 after the next clock edge. It takes priority over a start edge in the same cycle.
- R8: In off-delay mode (`MODE` = `MODE_OFF`, encoding 1), a falling edge of `run_i` in a cycle without `clr_i` loads `preset_i` into `remain_o` and starts the count. A preset of 0 leaves the timer stopped.
- R9: In off-delay mode, `status_o` equals the registered value of `run_i` ORed with "count still going". It is therefore high while the input is high, one cycle late, and it falls after the edge at which the count reaches 0.
- R10: While `rst_ni` is low, `status_o` is 0 and `remain_o` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run input; its edges start the timer |
| clr_i | input | 1 | Explicit timer clear, stops the count and zeroes it |
| tick_i | input | 1 | Time-base enable; one decrement per high cycle |
| preset_i | input | CNT_W | Preset count loaded on a start edge |
| status_o | output | 1 | Timer status bit |
| remain_o | output | CNT_W | Remaining count |

## Verification
The bench targets these cases:
- A rising edge after expiry: a design that does not gate the start edge on the expired state would reload the count and drop the status bit.
- A rising edge mid-count: a design that ignores retriggering would let the remaining count run on instead of jumping back to the preset.
- A clear and a start edge in the same cycle: a design that gave the edge priority would come out of that cycle with a loaded count.
- A preset of 0: a design that waits one extra cycle, or one that counts down through the counter's wrap, would be caught.
- A falling run input in on-delay mode: a design that treated it as a stop or clear would freeze or zero the count.
- The off-delay instance is driven with the same stimulus and checked for the status bit holding through the whole count.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic {
    MODE_ON_RET = 1'b0,
    MODE_OFF    = 1'b1
  } mode_e;
endpackage

// File: rtl/rdt_edge.sv
module rdt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o,
  output logic level_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end

  assign rise_o  = run_i & ~run_q;
  assign fall_o  = ~run_i & run_q;
  assign level_o = run_q;
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;

  assign step     = run_q & tick_i;
  // expiry event: zero preset on load, or last tick of a running count
  assign expire_o = ~clr_i & ((load_i & (preset_i == ZERO)) |
                              (~load_i & step & (cnt_q == ONE)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
      run_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= ZERO;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= preset_i;
      run_q <= (preset_i != ZERO);
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) run_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_q == $past(preset_i)));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - ONE));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i && !clr_i) |=> $stable(cnt_q));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == ZERO && !run_q));
endmodule

// File: rtl/rdt_status.sv
module rdt_status
  import rdt_pkg::*;
#(
  parameter mode_e MODE = MODE_ON_RET
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic level_i,
  input  logic running_i,
  input  logic expire_i,
  output logic start_o,
  output logic status_o
);
  generate
    if (MODE == MODE_ON_RET) begin : g_on
      logic done_q;
      logic unused_on;
      assign unused_on = ^{fall_i, level_i, running_i};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       done_q <= 1'b0;
        else if (clr_i)    done_q <= 1'b0;
        else if (expire_i) done_q <= 1'b1;
      end

      // expired timer ignores edges until cleared
      assign start_o  = rise_i & ~done_q;
      assign status_o = done_q;

      assert_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_q && !clr_i) |=> done_q);
      assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_i && !clr_i) |=> done_q);
      assert_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !done_q);
    end else begin : g_off
      logic unused_off;
      assign unused_off = ^{rise_i, expire_i, clk_i, rst_ni, clr_i};

      assign start_o  = fall_i;
      assign status_o = level_i | running_i;
    end
  endgenerate
endmodule

// File: rtl/rdt_timer.sv
module rdt_timer
  import rdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter mode_e       MODE  = MODE_ON_RET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             status_o,
  output logic [CNT_W-1:0] remain_o
);
  logic rise, fall, level;
  logic start, running, expire;

  rdt_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .rise_o  (rise),
    .fall_o  (fall),
    .level_o (level)
  );

  rdt_status #(.MODE(MODE)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .level_i   (level),
    .running_i (running),
    .expire_i  (expire),
    .start_o   (start),
    .status_o  (status_o)
  );

  rdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .load_i    (start),
    .tick_i    (tick_i),
    .preset_i  (preset_i),
    .cnt_o     (remain_o),
    .running_o (running),
    .expire_o  (expire)
  );

  generate
    if (MODE == MODE_OFF) begin : g_off_chk
      assert_off_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall && !clr_i && preset_i != '0) |=> (running && status_o));
    end else begin : g_on_chk
      assert_fall_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall && !clr_i && status_o) |=> status_o);
    end
  endgenerate
endmodule

// File: tb/rdt_timer_test.sv
`timescale 1ns/100ps
module rdt_timer_test;
  import rdt_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, clr = 1'b0, tick = 1'b0;
  logic [W-1:0] preset = '0;
  logic st_on, st_off;
  logic [W-1:0] rem_on, rem_off;

  always #2.5 clk = ~clk;

  rdt_timer #(.CNT_W(W), .MODE(MODE_ON_RET)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clr_i(clr), .tick_i(tick),
    .preset_i(preset), .status_o(st_on), .remain_o(rem_on));

  rdt_timer #(.CNT_W(W), .MODE(MODE_OFF)) uut_off (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clr_i(clr), .tick_i(tick),
    .preset_i(preset), .status_o(st_off), .remain_o(rem_off));

  typedef struct {
    int           due;
    bit           off;
    bit           st;
    logic [W-1:0] rem;
    string        req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural expectation per mode (index 0 on-delay, 1 off-delay)
  bit           m_rq[2], m_run[2], m_done[2];
  logic [W-1:0] m_cnt[2];

  task automatic model(int k, string req);
    bit r, f, s;
    exp_t e;
    r = run & ~m_rq[k];
    f = ~run & m_rq[k];
    s = (k == 1) ? f : (r & ~m_done[k]);
    if (clr) begin
      m_cnt[k] = '0; m_run[k] = 0; m_done[k] = 0;
    end else if (s) begin
      m_cnt[k] = preset; m_run[k] = (preset != 0); m_done[k] = (preset == 0);
    end else if (m_run[k] && tick) begin
      m_cnt[k] = m_cnt[k] - 1;
      if (m_cnt[k] == 0) begin m_run[k] = 0; m_done[k] = 1; end
    end
    m_rq[k] = run;
    e.due = cyc + 1;
    e.off = (k == 1);
    e.st  = (k == 1) ? (m_rq[k] | m_run[k]) : m_done[k];
    e.rem = m_cnt[k];
    e.req = req;
    q.push_back(e);
  endtask

  task automatic step(bit r, bit c, bit t, logic [W-1:0] p, string req_on, string req_off);
    @(posedge clk); #1;
    run = r; clr = c; tick = t; preset = p;
    model(0, req_on);
    model(1, req_off);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: compares results after the edge each expectation is due
  always @(posedge clk) begin
    cyc++;
    #3;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit a_st;
      logic [W-1:0] a_rem;
      e = q.pop_front();
      a_st  = e.off ? st_off : st_on;
      a_rem = e.off ? rem_off : rem_on;
      n_chk++;
      if (a_st !== e.st || a_rem !== e.rem) begin
        n_bad++;
        $display("FAIL %s %s: status=%0b remain=%0d expected status=%0b remain=%0d",
                 e.req, e.off ? "off" : "on", a_st, a_rem, e.st, e.rem);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_rq[k] = 0; m_run[k] = 0; m_done[k] = 0; m_cnt[k] = '0;
    end
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (st_on !== 1'b0 || rem_on !== '0 || st_off !== 1'b0 || rem_off !== '0) begin
      n_bad++;
      $display("FAIL R10: status=%0b/%0b remain=%0d/%0d expected 0/0 0/0",
               st_on, st_off, rem_on, rem_off);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    step(0, 0, 0, 5, "R10", "R10");
    step(1, 0, 0, 5, "R1", "R9");
    repeat (3) step(1, 0, 1, 5, "R2", "R9");
    step(1, 0, 0, 5, "R2", "R9");
    step(0, 0, 1, 5, "R4", "R8");
    repeat (4) step(0, 0, 1, 5, "R3", "R9");
    step(1, 0, 0, 5, "R6", "R9");
    step(0, 0, 1, 5, "R6", "R9");
    step(1, 0, 1, 5, "R6", "R9");
    step(1, 1, 0, 5, "R7", "R7");
    step(0, 0, 0, 0, "R7", "R8");
    step(1, 0, 0, 0, "R3", "R9");
    step(0, 1, 0, 0, "R7", "R8");
    step(1, 1, 0, 5, "R7", "R7");
    step(0, 0, 0, 6, "R7", "R8");
    step(1, 0, 0, 6, "R1", "R9");
    repeat (3) step(1, 0, 1, 6, "R2", "R9");
    step(0, 0, 1, 6, "R4", "R8");
    step(1, 0, 0, 6, "R5", "R9");
    step(1, 0, 1, 6, "R5", "R9");
    step(0, 0, 0, 3, "R4", "R8");
    repeat (4) step(0, 0, 1, 3, "R2", "R9");
    step(0, 0, 0, 3, "R9", "R9");
    step(0, 1, 0, 3, "R7", "R7");
    for (int i = 0; i < 400; i++)
      step($urandom % 2, ($urandom % 16) == 0, $urandom % 2, W'($urandom % 8), "R2", "R9");
    step(0, 0, 0, 0, "R2", "R9");
    repeat (2) @(posedge clk);
    #4;
    done = 1;
    summary();
    $finish;
  end
endmodule